// File: doc/BRIEF.md
# Video Field Timing Generator with Vertical Lock

This block produces all horizontal and vertical timing for a 525-line interlaced decoder from one dot-rate clock. A two-stage divider makes a character-rate strobe and then line-rate strobes. These are a one-cycle line tick, a tick at twice line rate, and a square wave that is high for the first half of each line. A line counter advances on the line tick and wraps once per field. Fields alternate between a long and a short length so that two fields make one full frame. On each wrap the counter emits an internal vertical pulse and flips a field-parity flag. It also decodes a data-recovery window, a display window and a per-line scroll tick limited to the display lines.

An external vertical reference keeps the counter in phase. A select input picks the reference from one of two sources: a pulse recovered from composite sync, or a dedicated vertical input. While unlocked, every reference edge forces the next line boundary to become a field start, so the timing follows the reference pulse for pulse. Once a programmable number of consecutive fields has seen the reference arrive within one line of the internal pulse, the block reports lock. The counter then free-runs and ignores the reference. Lock is only given up after a second programmable number of consecutive fields without a coincident reference.

Top module: `video_field_timer`

## Requirements
- R1: `char_tick` pulses for one cycle every DOTS_PER_CHAR cycles. `h_tick` pulses for one cycle every DOTS_PER_CHAR*CHARS_PER_LINE cycles, always together with `char_tick`. `h2_tick` pulses twice per line: at the end of character CHARS_PER_LINE/2-1 and together with `h_tick`. `hsqr` is high during the first CHARS_PER_LINE/2 characters of each line.
- R2: With no reference, consecutive fields alternate in length. A field started while `field_odd`=1 lasts (LINES_PER_FRAME+1)/2 lines (263). A field started while `field_odd`=0 lasts LINES_PER_FRAME/2 lines (262). `vpulse` is a one-cycle pulse in the cycle of the `h_tick` that ends a field.
- R3: `line_num` counts 1, 2, … up to the field length and is 1 in the cycle after `vpulse`. After reset, `line_num`=1, `field_odd`=1, `locked`=0 and `vpulse`=0.
- R4: `recov_win` is high exactly while `line_num` is in 21..42. `disp_win` is high exactly while `line_num` is in 43..237.
- R5: `scroll_tick` is `h_tick` qualified by `disp_win`, so it fires 195 times per field.
- R6: `vsrc_sel`=0 takes the reference from `comp_vref`, and `vsrc_sel`=1 takes it from `ext_vref`. Only a rising edge of the selected input counts, and the other input has no effect.
- R7: While `locked`=0, a reference edge arriving during a line makes the `h_tick` that ends that line a `vpulse`, so `line_num` is 1 in the following line.
- R8: A field scores a hit if a reference edge arrived while `line_num` was the field's last line, the line before it, or line 1. The score is taken at the `h_tick` ending line 2. `locked` rises at that score once `lock_fields` consecutive hits have been counted.
- R9: While `locked`=1, reference edges never move `line_num`. `locked` falls at the score that completes `unlock_fields` consecutive misses, and a hit clears the miss count.
- R10: `field_odd` inverts in the cycle after every `vpulse` and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsrc_sel | input | 1 | Reference select: 0 composite-derived, 1 dedicated |
| comp_vref | input | 1 | Vertical pulse recovered from composite sync |
| ext_vref | input | 1 | Dedicated vertical reference input |
| lock_fields | input | THR_W | Consecutive hits needed to lock |
| unlock_fields | input | THR_W | Consecutive misses needed to unlock |
| char_tick | output | 1 | Character-rate strobe |
| h_tick | output | 1 | Line-rate strobe |
| h2_tick | output | 1 | Twice-line-rate strobe |
| hsqr | output | 1 | Line-rate square wave |
| scroll_tick | output | 1 | Line tick during display lines |
| vpulse | output | 1 | Internal vertical pulse |
| field_odd | output | 1 | Field parity flag |
| line_num | output | LINE_W | Current line within the field |
| recov_win | output | 1 | Data-recovery line window |
| disp_win | output | 1 | Display line window |
| locked | output | 1 | Vertical lock indicator |

## Verification
The bench builds the block with DOTS_PER_CHAR=2 and CHARS_PER_LINE=4, so each line lasts eight cycles. The full 525-line frame and the real window limits are kept, which lets a complete field of about 2100 cycles be walked line by line against an independent line count. This short line also makes the multi-field lock and unlock sequences affordable, including threshold changes at run time down to one field.

// File: rtl/vft_pkg.sv
package vft_pkg;
  typedef enum logic {
    LK_SEARCH = 1'b0,
    LK_HOLD   = 1'b1
  } lock_state_t;
endpackage

// File: rtl/vft_hdiv.sv
module vft_hdiv #(
  parameter int DOTS_PER_CHAR  = 8,
  parameter int CHARS_PER_LINE = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic char_tick,
  output logic h_tick,
  output logic h2_tick,
  output logic hsqr
);
  localparam int DW   = (DOTS_PER_CHAR > 1) ? $clog2(DOTS_PER_CHAR) : 1;
  localparam int CW   = (CHARS_PER_LINE > 1) ? $clog2(CHARS_PER_LINE) : 1;
  localparam int HALF = CHARS_PER_LINE / 2;

  logic [DW-1:0] dot_q, dot_d;
  logic [CW-1:0] chr_q, chr_d;
  logic          chr_last;

  always_comb begin
    char_tick = (dot_q == DW'(DOTS_PER_CHAR - 1));
    dot_d     = char_tick ? '0 : dot_q + 1'b1;
    chr_last  = (chr_q == CW'(CHARS_PER_LINE - 1));
    chr_d     = chr_q;
    if (char_tick) chr_d = chr_last ? '0 : chr_q + 1'b1;
    h_tick    = char_tick & chr_last;
    h2_tick   = char_tick & (chr_last | (chr_q == CW'(HALF - 1)));
    hsqr      = (chr_q < CW'(HALF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q <= '0;
      chr_q <= '0;
    end else begin
      dot_q <= dot_d;
      chr_q <= chr_d;
    end
  end
endmodule

// File: rtl/vft_vcount.sv
module vft_vcount #(
  parameter int LINES_PER_FRAME = 525,
  parameter int LINE_W          = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_tick,
  input  logic              resync,
  output logic              vpulse,
  output logic              field_odd,
  output logic [LINE_W-1:0] line_q,
  output logic [LINE_W-1:0] field_len
);
  localparam int ODD_LEN  = (LINES_PER_FRAME + 1) / 2;
  localparam int EVEN_LEN = LINES_PER_FRAME / 2;

  logic [LINE_W-1:0] line_d;
  logic              odd_d;
  logic              at_end;

  always_comb begin
    field_len = field_odd ? LINE_W'(ODD_LEN) : LINE_W'(EVEN_LEN);
    at_end    = (line_q == field_len);
    vpulse    = h_tick & (at_end | resync);
    line_d    = line_q;
    odd_d     = field_odd;
    if (h_tick) begin
      if (vpulse) begin
        line_d = LINE_W'(1);
        odd_d  = ~field_odd;
      end else begin
        line_d = line_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q    <= LINE_W'(1);
      field_odd <= 1'b1;
    end else if (h_tick) begin
      line_q    <= line_d;
      field_odd <= odd_d;
    end
  end
endmodule

// File: rtl/vft_vlock.sv
module vft_vlock
  import vft_pkg::*;
#(
  parameter int LINE_W = 9,
  parameter int THR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_tick,
  input  logic [LINE_W-1:0] line_q,
  input  logic [LINE_W-1:0] field_len,
  input  logic              vsrc_sel,
  input  logic              comp_vref,
  input  logic              ext_vref,
  input  logic [THR_W-1:0]  lock_fields,
  input  logic [THR_W-1:0]  unlock_fields,
  output logic              resync,
  output logic              locked
);
  lock_state_t    st_q, st_d;
  logic [THR_W-1:0] cnt_q, cnt_d;
  logic           ref_q, pend_q, pend_d, hit_q, hit_d;
  logic           ref_in, ref_rise, in_win, score;
  logic [THR_W:0] cnt_inc;

  always_comb begin
    ref_in   = vsrc_sel ? ext_vref : comp_vref;
    ref_rise = ref_in & ~ref_q;
    in_win   = (line_q == LINE_W'(1)) || (line_q == field_len) ||
               (line_q == field_len - 1'b1);
    score    = h_tick & (line_q == LINE_W'(2));
    pend_d   = (pend_q & ~h_tick) | ref_rise;
    hit_d    = score ? 1'b0 : hit_q;
    if (ref_rise && in_win) hit_d = 1'b1;
    resync   = pend_q & (st_q == LK_SEARCH);
    locked   = (st_q == LK_HOLD);
    cnt_inc  = {1'b0, cnt_q} + 1'b1;
    st_d     = st_q;
    cnt_d    = cnt_q;
    if (score) begin
      case (st_q)
        LK_SEARCH: begin
          if (!hit_q) cnt_d = '0;
          else if (cnt_inc >= {1'b0, lock_fields}) begin
            st_d  = LK_HOLD;
            cnt_d = '0;
          end else cnt_d = cnt_inc[THR_W-1:0];
        end
        default: begin
          if (hit_q) cnt_d = '0;
          else if (cnt_inc >= {1'b0, unlock_fields}) begin
            st_d  = LK_SEARCH;
            cnt_d = '0;
          end else cnt_d = cnt_inc[THR_W-1:0];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LK_SEARCH;
      cnt_q  <= '0;
      ref_q  <= 1'b0;
      pend_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      ref_q  <= ref_in;
      pend_q <= pend_d;
      hit_q  <= hit_d;
    end
  end
endmodule

// File: rtl/video_field_timer.sv
module video_field_timer #(
  parameter int DOTS_PER_CHAR   = 8,
  parameter int CHARS_PER_LINE  = 64,
  parameter int LINES_PER_FRAME = 525,
  parameter int RECOV_FIRST     = 21,
  parameter int RECOV_LAST      = 42,
  parameter int DISP_FIRST      = 43,
  parameter int DISP_LAST       = 237,
  parameter int THR_W           = 4,
  localparam int ODD_LEN        = (LINES_PER_FRAME + 1) / 2,
  localparam int LINE_W         = $clog2(ODD_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsrc_sel,
  input  logic              comp_vref,
  input  logic              ext_vref,
  input  logic [THR_W-1:0]  lock_fields,
  input  logic [THR_W-1:0]  unlock_fields,
  output logic              char_tick,
  output logic              h_tick,
  output logic              h2_tick,
  output logic              hsqr,
  output logic              scroll_tick,
  output logic              vpulse,
  output logic              field_odd,
  output logic [LINE_W-1:0] line_num,
  output logic              recov_win,
  output logic              disp_win,
  output logic              locked
);
  logic [1:0]        rst_sync;
  logic              rst_i;
  logic              resync;
  logic [LINE_W-1:0] field_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  vft_hdiv #(
    .DOTS_PER_CHAR (DOTS_PER_CHAR),
    .CHARS_PER_LINE(CHARS_PER_LINE)
  ) hdiv_i (
    .clk(clk), .rst_n(rst_i), .char_tick(char_tick),
    .h_tick(h_tick), .h2_tick(h2_tick), .hsqr(hsqr)
  );

  vft_vcount #(
    .LINES_PER_FRAME(LINES_PER_FRAME),
    .LINE_W         (LINE_W)
  ) vcount_i (
    .clk(clk), .rst_n(rst_i), .h_tick(h_tick), .resync(resync),
    .vpulse(vpulse), .field_odd(field_odd), .line_q(line_num),
    .field_len(field_len)
  );

  vft_vlock #(
    .LINE_W(LINE_W),
    .THR_W (THR_W)
  ) vlock_i (
    .clk(clk), .rst_n(rst_i), .h_tick(h_tick), .line_q(line_num),
    .field_len(field_len), .vsrc_sel(vsrc_sel), .comp_vref(comp_vref),
    .ext_vref(ext_vref), .lock_fields(lock_fields),
    .unlock_fields(unlock_fields), .resync(resync), .locked(locked)
  );

  always_comb begin
    recov_win   = (line_num >= LINE_W'(RECOV_FIRST)) && (line_num <= LINE_W'(RECOV_LAST));
    disp_win    = (line_num >= LINE_W'(DISP_FIRST)) && (line_num <= LINE_W'(DISP_LAST));
    scroll_tick = h_tick & disp_win;
  end
endmodule

// File: rtl/vft_checks.sv
module vft_checks #(
  parameter int LINE_W     = 9,
  parameter int ODD_LEN    = 263,
  parameter int EVEN_LEN   = 262,
  parameter int DISP_FIRST = 43,
  parameter int DISP_LAST  = 237
) (
  input logic              clk,
  input logic              rst_n,
  input logic              char_tick,
  input logic              h_tick,
  input logic              h2_tick,
  input logic              scroll_tick,
  input logic              vpulse,
  input logic              field_odd,
  input logic [LINE_W-1:0] line_num,
  input logic              recov_win,
  input logic              disp_win,
  input logic              locked
);
  assert_h_on_char_R1: assert property (@(posedge clk) disable iff (!rst_n)
    h_tick |-> (char_tick && h2_tick));

  assert_vpulse_on_h_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vpulse |-> h_tick);

  assert_line_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vpulse |=> (line_num == LINE_W'(1)));

  assert_line_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_num >= LINE_W'(1)) && (line_num <= LINE_W'(ODD_LEN)));

  assert_windows_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(recov_win && disp_win));

  assert_scroll_in_disp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    scroll_tick |-> (h_tick && (line_num >= LINE_W'(DISP_FIRST)) &&
                     (line_num <= LINE_W'(DISP_LAST))));

  assert_lock_at_score_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(h_tick) && ($past(line_num) == LINE_W'(2))));

  assert_flywheel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vpulse && locked) |->
      (line_num == (field_odd ? LINE_W'(ODD_LEN) : LINE_W'(EVEN_LEN))));

  assert_field_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vpulse |=> (field_odd != $past(field_odd)));
endmodule

bind video_field_timer vft_checks #(
  .LINE_W    (LINE_W),
  .ODD_LEN   ((LINES_PER_FRAME + 1) / 2),
  .EVEN_LEN  (LINES_PER_FRAME / 2),
  .DISP_FIRST(DISP_FIRST),
  .DISP_LAST (DISP_LAST)
) chk_i (
  .clk(clk), .rst_n(rst_n), .char_tick(char_tick), .h_tick(h_tick),
  .h2_tick(h2_tick), .scroll_tick(scroll_tick), .vpulse(vpulse),
  .field_odd(field_odd), .line_num(line_num), .recov_win(recov_win),
  .disp_win(disp_win), .locked(locked)
);

// File: tb/video_field_timer_tb_top.sv
module video_field_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DPC   = 2;
  localparam int CPL   = 4;
  localparam int LPF   = 525;
  localparam int THR_W = 4;
  localparam int ODD_L = (LPF + 1) / 2;
  localparam int EVN_L = LPF / 2;
  localparam int LW    = $clog2(ODD_L + 1);
  localparam int LINE_CYC = DPC * CPL;

  logic clk = 1'b0;
  logic rst_n, vsrc_sel, comp_vref, ext_vref;
  logic [THR_W-1:0] lock_fields, unlock_fields;
  logic char_tick, h_tick, h2_tick, hsqr, scroll_tick, vpulse, field_odd;
  logic recov_win, disp_win, locked;
  logic [LW-1:0] line_num;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  video_field_timer #(
    .DOTS_PER_CHAR(DPC), .CHARS_PER_LINE(CPL), .LINES_PER_FRAME(LPF), .THR_W(THR_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .vsrc_sel(vsrc_sel), .comp_vref(comp_vref),
    .ext_vref(ext_vref), .lock_fields(lock_fields), .unlock_fields(unlock_fields),
    .char_tick(char_tick), .h_tick(h_tick), .h2_tick(h2_tick), .hsqr(hsqr),
    .scroll_tick(scroll_tick), .vpulse(vpulse), .field_odd(field_odd),
    .line_num(line_num), .recov_win(recov_win), .disp_win(disp_win), .locked(locked)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_line(input int n);
    @(negedge clk);
    while (int'(line_num) == n) @(negedge clk);
    while (int'(line_num) != n) @(negedge clk);
  endtask

  task automatic pulse_ref(input bit use_ext);
    if (use_ext) ext_vref = 1'b1; else comp_vref = 1'b1;
    @(negedge clk);
    ext_vref  = 1'b0;
    comp_vref = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; vsrc_sel = 1'b0; comp_vref = 1'b0; ext_vref = 1'b0;
    lock_fields = 4'd4; unlock_fields = 4'd4;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(int'(line_num) == 1, "R3 reset line", int'(line_num), 1);
    chk(field_odd == 1'b1, "R3 reset field_odd", int'(field_odd), 1);
    chk(locked == 1'b0, "R3 reset locked", int'(locked), 0);
  endtask

  task automatic t_horiz;
    int nc = 0, nh = 0, nh2 = 0, nsq = 0, last_h = -1, gap_err = 0;
    for (int i = 0; i < 8 * LINE_CYC; i++) begin
      @(negedge clk);
      if (char_tick) nc++;
      if (h2_tick) nh2++;
      if (hsqr) nsq++;
      if (h_tick) begin
        nh++;
        if (!char_tick) gap_err++;
        if (last_h >= 0 && i - last_h != LINE_CYC) gap_err++;
        last_h = i;
      end
    end
    chk(nc == 8 * CPL, "R1 char ticks", nc, 8 * CPL);
    chk(nh == 8, "R1 line ticks", nh, 8);
    chk(nh2 == 16, "R1 double-rate ticks", nh2, 16);
    chk(nsq == 4 * LINE_CYC, "R1 square high cycles", nsq, 4 * LINE_CYC);
    chk(gap_err == 0, "R1 line tick spacing", gap_err, 0);
  endtask

  task automatic t_freerun;
    bit fo;
    int exp_line, cyc, errs, scr, exp_len;
    @(negedge clk);
    while (!vpulse) @(negedge clk);
    for (int f = 0; f < 2; f++) begin
      fo = field_odd;
      exp_len = fo ? EVN_L : ODD_L;
      exp_line = 1; cyc = 0; errs = 0; scr = 0;
      @(negedge clk);
      chk(field_odd == ~fo, "R10 parity flip", int'(field_odd), int'(~fo));
      forever begin
        cyc++;
        if (int'(line_num) != exp_line) errs++;
        if (recov_win != (exp_line >= 21 && exp_line <= 42)) errs++;
        if (disp_win != (exp_line >= 43 && exp_line <= 237)) errs++;
        if (scroll_tick != (h_tick && exp_line >= 43 && exp_line <= 237)) errs++;
        if (scroll_tick) scr++;
        if (vpulse) break;
        if (h_tick) exp_line++;
        @(negedge clk);
      end
      chk(cyc == exp_len * LINE_CYC, "R2 field length", cyc, exp_len * LINE_CYC);
      chk(exp_line == exp_len, "R3 last line", exp_line, exp_len);
      chk(errs == 0, "R4 line and window trace", errs, 0);
      chk(scr == 195, "R5 scroll ticks per field", scr, 195);
    end
  endtask

  task automatic t_source;
    vsrc_sel = 1'b0;
    wait_line(100); pulse_ref(1'b1); repeat (9) @(negedge clk);
    chk(int'(line_num) == 101, "R6 unselected input ignored", int'(line_num), 101);
    wait_line(100); pulse_ref(1'b0); repeat (9) @(negedge clk);
    chk(int'(line_num) == 1, "R7 resync from composite", int'(line_num), 1);
    vsrc_sel = 1'b1;
    wait_line(100); pulse_ref(1'b0); repeat (9) @(negedge clk);
    chk(int'(line_num) == 101, "R6 composite ignored when dedicated chosen", int'(line_num), 101);
    wait_line(100); pulse_ref(1'b1); repeat (9) @(negedge clk);
    chk(int'(line_num) == 1, "R7 resync from dedicated", int'(line_num), 1);
  endtask

  task automatic t_lock;
    for (int k = 1; k <= 4; k++) begin
      wait_line(262); pulse_ref(1'b1); wait_line(3);
      chk(locked == (k >= 4), "R8 lock after consecutive hits", int'(locked), int'(k >= 4));
    end
  endtask

  task automatic t_flywheel;
    wait_line(100); pulse_ref(1'b1); repeat (9) @(negedge clk);
    chk(int'(line_num) == 101, "R9 locked ignores reference", int'(line_num), 101);
    wait_line(3);
    chk(locked == 1'b1, "R9 one miss keeps lock", int'(locked), 1);
    wait_line(3);
    chk(locked == 1'b1, "R9 two misses keep lock", int'(locked), 1);
    wait_line(262); pulse_ref(1'b1); wait_line(3);
    chk(locked == 1'b1, "R9 hit clears misses", int'(locked), 1);
    for (int m = 1; m <= 4; m++) begin
      wait_line(3);
      chk(locked == (m < 4), "R9 unlock after consecutive misses", int'(locked), int'(m < 4));
    end
    wait_line(100); pulse_ref(1'b1); repeat (9) @(negedge clk);
    chk(int'(line_num) == 1, "R7 follows again after unlock", int'(line_num), 1);
  endtask

  task automatic t_thresh;
    lock_fields = 4'd2; unlock_fields = 4'd1;
    wait_line(262); pulse_ref(1'b1); wait_line(3);
    chk(locked == 1'b0, "R8 short threshold one hit", int'(locked), 0);
    wait_line(262); pulse_ref(1'b1); wait_line(3);
    chk(locked == 1'b1, "R8 short threshold two hits", int'(locked), 1);
    wait_line(3);
    chk(locked == 1'b0, "R9 single miss unlock", int'(locked), 0);
  endtask

  initial begin
    t_reset();
    t_horiz();
    t_freerun();
    t_source();
    t_lock();
    t_flywheel();
    t_thresh();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule